// File: doc/BRIEF.md
# Dual-Bank Interrupt GPIO Controller

This block is a 32-pin general-purpose I/O controller on a simple 32-bit register bus. Software sets a direction mask and an output latch. Pins marked as inputs are sampled every clock, and the sampled values can be read back. Each input pin can raise an event on a rising edge, a falling edge, a high level or a low level, in any mix. A single event marks the pin in two separate status registers. Each status register has its own enable mask and its own interrupt line, so two consumers (for example an application core and a signal-processing core) can mask and acknowledge the same pin events independently.

A sticky wakeup request is raised when a qualifying event hits a pin that is enabled for wakeup. This happens only when a configuration register allows wakeups and selects a non-zero idle mode. Writing the soft-reset bit of that configuration register returns every other register to its reset value. The enable masks and the output latch also have set and clear alias addresses, so single bits can be changed without a read-modify-write. The debounce registers are plain storage.

Level detection runs every cycle. If a level condition is still present when its status bit is cleared, the bit is set again at once. Changing the direction mask or a level-detect mask therefore takes effect on the next cycle without any further action.

Top module: `gpio_dual_irq`

## Requirements
- R1: After hardware reset the direction mask (0x34) reads 0xFFFFFFFF, the control register (0x30) reads 2, and the identification register (0x00) reads the REV_ID parameter. The system status (0x14) always reads 1. All other registers read 0, and pin_out, irq_a, irq_b and wake_req are 0.
- R2: pin_out equals the output latch ANDed with the inverse of the direction mask, where a direction bit of 1 marks an input pin. The latch is loaded at 0x3C, has bits set by writing 1s at 0x94 and has bits cleared by writing 1s at 0x90.
- R3: The pin-input register (0x38) returns pin_in as sampled on the previous clock edge. Writes to 0x00, 0x14 and 0x38 are ignored.
- R4: On an input pin, a rising edge with its bit set in the rising mask (0x48), or a falling edge with its bit set in the falling mask (0x4C), sets that pin's bit in both status registers (0x18 and 0x28). A pin whose direction bit is 0 never sets status.
- R5: While an input pin is high and its bit is set in the high-level mask (0x44), or low and its bit is set in the low-level mask (0x40), its status bits in both banks are set every cycle. Clearing such a bit while the level persists leaves it set.
- R6: Writing 1s to a status register clears those bits. A detected event in the same cycle as the clear wins, and the bit stays set.
- R7: irq_a is the OR of status A (0x18) ANDed with enable A (0x1C). irq_b is the same for status B (0x28) and enable B (0x2C). The two banks are independent.
- R8: The alias pairs are: enable A set/clear at 0x64/0x60, enable B set/clear at 0x74/0x70, and wakeup-enable set/clear at 0x84/0x80. A set alias ORs the written 1s into the base register and a clear alias removes them. Reading any alias, including the output-latch aliases, returns its base register.
- R9: wake_req becomes 1 after an event on a pin whose bit is set in the wakeup-enable mask (0x20), but only while configuration bit 2 is 1 and configuration bits [4:3] are non-zero. Once set, it stays 1 until a hardware or soft reset.
- R10: A write to the configuration register (0x10) stores the written value ANDed with 0x1D. If bit 1 of the written value is 1, all other registers return to their R1 values and wake_req is cleared in the same cycle.
- R11: The control register keeps only bits [2:0]. The debounce-enable register (0x50) keeps 32 bits and the debounce-time register (0x54) keeps 8 bits. Reads of any unmapped or misaligned offset return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Driven levels, 0 on input pins |
| irq_a | output | 1 | Interrupt line of bank A |
| irq_b | output | 1 | Interrupt line of bank B |
| wake_req | output | 1 | Sticky wakeup request |

## Verification
The bound checker checks several properties on every cycle. It checks that pin_out never drives an input pin and that status bits rise only on pins that were inputs. It checks that a bit newly set in bank A is also present in bank B, that irq_a is low whenever enable A is empty, that wake_req stays high except across a soft reset, and that a soft reset restores the direction mask. The bench's scenarios cover the remaining behaviour. They sweep rising and falling edges across every pin, re-set a level-detected bit right after it is cleared, and make a clear collide with an event in the same cycle. They also check the wakeup qualification by configuration bits, the set and clear alias arithmetic, and the values read back after a soft reset.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;

    localparam int ADDR_W = 8;

    // register offsets decoded by software
    localparam logic [ADDR_W-1:0] OFS_IDENT      = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SYSCFG     = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SYSSTAT    = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_STS_A      = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ENA_A      = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_WAKE_ENA   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STS_B      = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_ENA_B      = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_CTRL       = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DIR        = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_PIN_IN     = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_PIN_OUT    = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_LVL_LO     = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_LVL_HI     = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_RISE       = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_FALL       = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_DB_EN      = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_DB_TIME    = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_ENA_A_CLR  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_ENA_A_SET  = 8'h64;
    localparam logic [ADDR_W-1:0] OFS_ENA_B_CLR  = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_ENA_B_SET  = 8'h74;
    localparam logic [ADDR_W-1:0] OFS_WAKE_CLR   = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_WAKE_SET   = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR    = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET    = 8'h94;

    localparam int CFG_W = 5;
    localparam logic [CFG_W-1:0] CFG_KEEP = 5'h1D;
    localparam int CFG_SRST_BIT = 1;
    localparam int CFG_WAKE_BIT = 2;
    localparam int CTRL_W = 3;
    localparam logic [CTRL_W-1:0] CTRL_RST = 3'd2;

    typedef enum logic [1:0] {
        ENA_HOLD,
        ENA_LOAD,
        ENA_SET,
        ENA_CLR
    } ena_op_e;

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lvl_lo,
    input  logic [W-1:0] lvl_hi,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] pin_now,
    output logic [W-1:0] evt
);

    logic [W-1:0] pin_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_now  <= '0;
            pin_prev <= '0;
        end else begin
            pin_now  <= pin_in;
            pin_prev <= pin_now;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic up, down, hi, lo;
        assign up   = pin_now[i] & ~pin_prev[i] & rise_en[i];
        assign down = ~pin_now[i] & pin_prev[i] & fall_en[i];
        assign hi   = pin_now[i] & lvl_hi[i];
        assign lo   = ~pin_now[i] & lvl_lo[i];
        assign evt[i] = dir_q[i] & (up | down | hi | lo);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_dual_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] evt,
    input  logic         sts_clr_we,
    input  ena_op_e      ena_op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] sts,
    output logic [W-1:0] ena,
    output logic         irq
);

    logic [W-1:0] clr_mask;
    assign clr_mask = sts_clr_we ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts <= '0;
            ena <= '0;
        end else if (soft_rst) begin
            sts <= '0;
            ena <= '0;
        end else begin
            // a fresh event overrides a clear in the same cycle
            sts <= (sts & ~clr_mask) | evt;
            unique case (ena_op)
                ENA_HOLD: ena <= ena;
                ENA_LOAD: ena <= wdata;
                ENA_SET:  ena <= ena | wdata;
                ENA_CLR:  ena <= ena & ~wdata;
            endcase
        end
    end

    assign irq = |(sts & ena);

endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
    import gpio_dual_pkg::*;
#(
    parameter int          W       = 32,
    parameter int          DBT_W   = 8,
    parameter logic [31:0] REV_ID  = 32'h0000_0025
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic              irq_a,
    output logic              irq_b,
    output logic              wake_req
);

    localparam int NBANK = 2;

    logic [CFG_W-1:0]  cfg_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [W-1:0]      dir_q, dout_q, lvl_lo_q, lvl_hi_q, rise_q, fall_q;
    logic [W-1:0]      wake_ena_q, db_en_q;
    logic [DBT_W-1:0]  db_time_q;
    logic              wake_q;

    logic [W-1:0]      pin_now, evt;
    logic [NBANK-1:0][W-1:0] sts, ena;
    logic [NBANK-1:0]  irq;
    logic              soft_rst, wake_hit;

    assign soft_rst = bus_we && (bus_addr == OFS_SYSCFG) && bus_wdata[CFG_SRST_BIT];

    gpio_evt_detect #(.W(W)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .dir_q   (dir_q),
        .lvl_lo  (lvl_lo_q),
        .lvl_hi  (lvl_hi_q),
        .rise_en (rise_q),
        .fall_en (fall_q),
        .pin_now (pin_now),
        .evt     (evt)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [ADDR_W-1:0] STS_OFS = (b == 0) ? OFS_STS_A     : OFS_STS_B;
        localparam logic [ADDR_W-1:0] ENA_OFS = (b == 0) ? OFS_ENA_A     : OFS_ENA_B;
        localparam logic [ADDR_W-1:0] SET_OFS = (b == 0) ? OFS_ENA_A_SET : OFS_ENA_B_SET;
        localparam logic [ADDR_W-1:0] CLR_OFS = (b == 0) ? OFS_ENA_A_CLR : OFS_ENA_B_CLR;

        ena_op_e op;
        always_comb begin
            op = ENA_HOLD;
            if (bus_we) begin
                if (bus_addr == ENA_OFS)      op = ENA_LOAD;
                else if (bus_addr == SET_OFS) op = ENA_SET;
                else if (bus_addr == CLR_OFS) op = ENA_CLR;
            end
        end

        gpio_irq_bank #(.W(W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .soft_rst   (soft_rst),
            .evt        (evt),
            .sts_clr_we (bus_we && (bus_addr == STS_OFS)),
            .ena_op     (op),
            .wdata      (bus_wdata),
            .sts        (sts[b]),
            .ena        (ena[b]),
            .irq        (irq[b])
        );
    end

    assign wake_hit = (|(evt & wake_ena_q)) && cfg_q[CFG_WAKE_BIT] && (|cfg_q[4:3]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            ctrl_q     <= CTRL_RST;
            dir_q      <= '1;
            dout_q     <= '0;
            lvl_lo_q   <= '0;
            lvl_hi_q   <= '0;
            rise_q     <= '0;
            fall_q     <= '0;
            wake_ena_q <= '0;
            db_en_q    <= '0;
            db_time_q  <= '0;
            wake_q     <= 1'b0;
        end else if (soft_rst) begin
            cfg_q      <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
            ctrl_q     <= CTRL_RST;
            dir_q      <= '1;
            dout_q     <= '0;
            lvl_lo_q   <= '0;
            lvl_hi_q   <= '0;
            rise_q     <= '0;
            fall_q     <= '0;
            wake_ena_q <= '0;
            db_en_q    <= '0;
            db_time_q  <= '0;
            wake_q     <= 1'b0;
        end else begin
            wake_q <= wake_q | wake_hit;
            if (bus_we) begin
                case (bus_addr)
                    OFS_SYSCFG:   cfg_q      <= bus_wdata[CFG_W-1:0] & CFG_KEEP;
                    OFS_CTRL:     ctrl_q     <= bus_wdata[CTRL_W-1:0];
                    OFS_DIR:      dir_q      <= bus_wdata;
                    OFS_PIN_OUT:  dout_q     <= bus_wdata;
                    OFS_OUT_SET:  dout_q     <= dout_q | bus_wdata;
                    OFS_OUT_CLR:  dout_q     <= dout_q & ~bus_wdata;
                    OFS_LVL_LO:   lvl_lo_q   <= bus_wdata;
                    OFS_LVL_HI:   lvl_hi_q   <= bus_wdata;
                    OFS_RISE:     rise_q     <= bus_wdata;
                    OFS_FALL:     fall_q     <= bus_wdata;
                    OFS_WAKE_ENA: wake_ena_q <= bus_wdata;
                    OFS_WAKE_SET: wake_ena_q <= wake_ena_q | bus_wdata;
                    OFS_WAKE_CLR: wake_ena_q <= wake_ena_q & ~bus_wdata;
                    OFS_DB_EN:    db_en_q    <= bus_wdata;
                    OFS_DB_TIME:  db_time_q  <= bus_wdata[DBT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_IDENT:    bus_rdata = REV_ID[W-1:0];
            OFS_SYSCFG:   bus_rdata = {{(W-CFG_W){1'b0}}, cfg_q};
            OFS_SYSSTAT:  bus_rdata = {{(W-1){1'b0}}, 1'b1};
            OFS_STS_A:    bus_rdata = sts[0];
            OFS_STS_B:    bus_rdata = sts[1];
            OFS_ENA_A, OFS_ENA_A_SET, OFS_ENA_A_CLR: bus_rdata = ena[0];
            OFS_ENA_B, OFS_ENA_B_SET, OFS_ENA_B_CLR: bus_rdata = ena[1];
            OFS_WAKE_ENA, OFS_WAKE_SET, OFS_WAKE_CLR: bus_rdata = wake_ena_q;
            OFS_CTRL:     bus_rdata = {{(W-CTRL_W){1'b0}}, ctrl_q};
            OFS_DIR:      bus_rdata = dir_q;
            OFS_PIN_IN:   bus_rdata = pin_now;
            OFS_PIN_OUT, OFS_OUT_SET, OFS_OUT_CLR: bus_rdata = dout_q;
            OFS_LVL_LO:   bus_rdata = lvl_lo_q;
            OFS_LVL_HI:   bus_rdata = lvl_hi_q;
            OFS_RISE:     bus_rdata = rise_q;
            OFS_FALL:     bus_rdata = fall_q;
            OFS_DB_EN:    bus_rdata = db_en_q;
            OFS_DB_TIME:  bus_rdata = {{(W-DBT_W){1'b0}}, db_time_q};
            default:      bus_rdata = '0;
        endcase
    end

    assign pin_out  = dout_q & ~dir_q;
    assign irq_a    = irq[0];
    assign irq_b    = irq[1];
    assign wake_req = wake_q;

endmodule

// File: rtl/gpio_dual_irq_chk.sv
module gpio_dual_irq_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         soft_rst,
    input logic [W-1:0] dir_q,
    input logic [W-1:0] pin_out,
    input logic [W-1:0] sts_a,
    input logic [W-1:0] sts_b,
    input logic [W-1:0] ena_a,
    input logic         irq_a,
    input logic         wake_req
);

    // R2
    pin_out_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & dir_q) == '0);

    // R4
    sts_input_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_a & ~$past(sts_a)) & ~$past(dir_q)) == '0);

    // R4
    bank_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_a & ~$past(sts_a) & ~sts_b) == '0);

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_a == '0) |-> !irq_a);

    // R9
    wake_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !soft_rst) |=> wake_req);

    // R10
    soft_rst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (dir_q == '1) && !wake_req);

endmodule

bind gpio_dual_irq gpio_dual_irq_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .dir_q    (dir_q),
    .pin_out  (pin_out),
    .sts_a    (sts[0]),
    .sts_b    (sts[1]),
    .ena_a    (ena[0]),
    .irq_a    (irq_a),
    .wake_req (wake_req)
);

// File: tb/tb_gpio_dual_irq.sv
`timescale 1ns/1ps
module tb_gpio_dual_irq;

    localparam logic [31:0] REV = 32'h0000_0025;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic        irq_a, irq_b, wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_dual_irq #(.W(32), .DBT_W(8), .REV_ID(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .irq_a(irq_a), .irq_b(irq_b), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1 chk(req, bus_rdata, exp);
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_all();
        wr(8'h18, '1);
        wr(8'h28, '1);
    endtask

    initial begin
        logic [7:0] zero_regs [13] = '{8'h10, 8'h18, 8'h1C, 8'h20, 8'h28, 8'h2C,
                                       8'h3C, 8'h40, 8'h44, 8'h48, 8'h4C, 8'h50, 8'h54};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 ident", 8'h00, REV);
        rdchk("R1 sysstat", 8'h14, 32'h1);
        rdchk("R1 dir", 8'h34, 32'hFFFF_FFFF);
        rdchk("R1 ctrl", 8'h30, 32'h2);
        foreach (zero_regs[k]) rdchk("R1 zero reg", zero_regs[k], 32'h0);
        chk("R1 outputs", {29'd0, irq_a, irq_b, wake_req}, 32'h0);
        chk("R1 pin_out", pin_out, 32'h0);

        // R4 edge sweep over every pin
        for (int i = 0; i < 32; i++) begin
            wr(8'h48, 32'h1 << i);
            wr(8'h4C, 32'h1 << i);
            set_pins(32'h1 << i);
            rdchk("R4 rise bankA", 8'h18, 32'h1 << i);
            rdchk("R4 rise bankB", 8'h28, 32'h1 << i);
            clr_all();
            set_pins(32'h0);
            rdchk("R4 fall bankB", 8'h28, 32'h1 << i);
            clr_all();
        end
        wr(8'h4C, 32'h0);

        // R4 output pin never sets status
        wr(8'h34, ~32'h20);
        wr(8'h48, 32'h20);
        set_pins(32'h20);
        rdchk("R4 output pin ignored", 8'h18, 32'h0);
        set_pins(32'h0);
        wr(8'h34, '1);
        wr(8'h48, 32'h0);

        // R2 output latch and pin_out masking
        wr(8'h3C, 32'hA5);
        wr(8'h94, 32'h100);
        wr(8'h90, 32'h5);
        rdchk("R2 latch", 8'h3C, 32'h1A0);
        #1 chk("R2 pin_out all inputs", pin_out, 32'h0);
        wr(8'h34, 32'hFFFF_0080);
        #1 chk("R2 pin_out", pin_out, 32'h1A0 & ~32'hFFFF_0080);
        wr(8'h34, '1);

        // R3 data-in and read-only registers
        set_pins(32'h1234_5678);
        rdchk("R3 pin in", 8'h38, 32'h1234_5678);
        wr(8'h38, 32'hDEAD_BEEF);
        rdchk("R3 pin in ro", 8'h38, 32'h1234_5678);
        wr(8'h00, 32'h0);
        rdchk("R3 ident ro", 8'h00, REV);
        wr(8'h14, 32'h0);
        rdchk("R3 sysstat ro", 8'h14, 32'h1);
        set_pins(32'h3000_1234);

        // R5 level detection
        wr(8'h44, 32'hF0F0_0000);
        repeat (2) @(negedge clk);
        rdchk("R5 high level", 8'h18, 32'h3000_0000);
        wr(8'h18, '1);
        rdchk("R5 re-set after clear", 8'h18, 32'h3000_0000);
        wr(8'h44, 32'h0);
        clr_all();
        rdchk("R5 cleared", 8'h18, 32'h0);
        wr(8'h40, 32'hF);
        repeat (2) @(negedge clk);
        rdchk("R5 low level", 8'h28, 32'hB);
        wr(8'h40, 32'h0);
        clr_all();
        set_pins(32'h0);
        clr_all();

        // R6 clear collides with event
        wr(8'h48, 32'h1);
        @(negedge clk);
        pin_in = 32'h1;
        wr(8'h18, 32'h1);
        rdchk("R6 event wins", 8'h18, 32'h1);
        wr(8'h18, 32'h1);
        rdchk("R6 w1c", 8'h18, 32'h0);
        clr_all();
        set_pins(32'h0);

        // R7 independent interrupt banks
        wr(8'h48, 32'h3);
        set_pins(32'h3);
        wr(8'h1C, 32'h2);
        #1 chk("R7 irq_a", {31'd0, irq_a}, 32'h1);
        chk("R7 irq_b", {31'd0, irq_b}, 32'h0);
        wr(8'h2C, 32'h4);
        #1 chk("R7 irq_b masked", {31'd0, irq_b}, 32'h0);
        wr(8'h18, 32'h2);
        #1 chk("R7 irq_a cleared", {31'd0, irq_a}, 32'h0);
        wr(8'h74, 32'h1);
        #1 chk("R7 irq_b set", {31'd0, irq_b}, 32'h1);
        rdchk("R8 enB set", 8'h2C, 32'h5);

        // R8 aliases
        wr(8'h1C, 32'h0);
        wr(8'h64, 32'hF);
        wr(8'h60, 32'h3);
        rdchk("R8 enA clr alias read", 8'h60, 32'hC);
        rdchk("R8 enA set alias read", 8'h64, 32'hC);
        wr(8'h70, 32'h5);
        rdchk("R8 enB clr", 8'h2C, 32'h0);
        wr(8'h84, 32'hF0);
        wr(8'h80, 32'h30);
        rdchk("R8 wake en", 8'h20, 32'hC0);
        rdchk("R8 wake alias read", 8'h80, 32'hC0);
        rdchk("R8 out alias read", 8'h94, 32'h1A0);
        wr(8'h1C, 32'h0);
        set_pins(32'h0);
        clr_all();

        // R9 wakeup qualification
        wr(8'h20, 32'h8);
        wr(8'h48, 32'h8);
        wr(8'h10, 32'h04);
        set_pins(32'h8);
        #1 chk("R9 no wake idle mode 0", {31'd0, wake_req}, 32'h0);
        set_pins(32'h0);
        wr(8'h10, 32'h0C);
        set_pins(32'h8);
        #1 chk("R9 wake", {31'd0, wake_req}, 32'h1);
        clr_all();
        wr(8'h10, 32'h00);
        #1 chk("R9 sticky", {31'd0, wake_req}, 32'h1);

        // R11 storage-only and unmapped
        wr(8'h30, 32'hFF);
        rdchk("R11 ctrl", 8'h30, 32'h7);
        wr(8'h50, 32'h1234_5678);
        rdchk("R11 db en", 8'h50, 32'h1234_5678);
        wr(8'h54, 32'h1FF);
        rdchk("R11 db time", 8'h54, 32'hFF);
        rdchk("R11 unmapped", 8'h58, 32'h0);
        rdchk("R11 misaligned", 8'h19, 32'h0);

        // R10 soft reset
        wr(8'h34, 32'h0);
        wr(8'h10, 32'h1F);
        rdchk("R10 cfg masked", 8'h10, 32'h1D);
        chk("R10 wake cleared", {31'd0, wake_req}, 32'h0);
        rdchk("R10 dir", 8'h34, 32'hFFFF_FFFF);
        rdchk("R10 ctrl", 8'h30, 32'h2);
        rdchk("R10 db en", 8'h50, 32'h0);
        rdchk("R10 wake en", 8'h20, 32'h0);
        rdchk("R10 rise", 8'h48, 32'h0);
        rdchk("R10 latch", 8'h3C, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule